// File: doc/BRIEF.md
# Power Plant Mode Sequencer

This block steps a fuel-fed power plant through its whole run: Off, Startup, Warmup, Offline, Online and Shutdown. Event detectors elsewhere in the chip report what happens. Each event arrives as a single-cycle pulse: a power-button press, initialization done, operating temperature reached, a command to go online or offline, an overload, a detected fault, or a request to stop. The sequencer turns these pulses into the current mode. From that mode it drives four actuator enables: load connection, supply enable, gas valves and a forced fan.

Shutdown does not wait for an external signal. An internal counter is loaded when the plant enters Shutdown and holds the plant there for a set number of cycles, so the fan can purge the stack before the plant returns to Off. A fault or stop request beats every other event that arrives in the same cycle. An overload while Online only drops the plant back to Offline.

Top module: `plant_mode_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, mode_o reads Off and all four actuator outputs are 0. The mode code is 0 for Off, 1 for Startup, 2 for Warmup, 3 for Offline, 4 for Online and 5 for Shutdown.
- R2: In Off all actuator outputs are 0. A power pulse moves the plant to Startup on the next clock edge, and every other event leaves it in Off.
- R3: In Startup only psu_en is 1. An init_done pulse moves the plant to Warmup.
- R4: In Warmup psu_en and valve_open are 1 and load_en is 0. A temp_ok pulse moves the plant to Offline.
- R5: In Offline psu_en and valve_open are 1 and load_en is 0. A go_online pulse moves the plant to Online.
- R6: In Online load_en, psu_en and valve_open are 1. Either a go_offline pulse or an overload pulse moves the plant back to Offline.
- R7: In Startup, Warmup, Offline or Online, a fault or stop_req pulse moves the plant to Shutdown. This wins over any other event in the same cycle.
- R8: In Shutdown psu_en and fan_force are 1, and valve_open and load_en are 0. The plant stays in Shutdown for exactly DRAIN_CYCLES cycles and then enters Off, whatever events arrive during that time.
- R9: An event that the current mode does not accept leaves the mode and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| power | input | 1 | Power-button press pulse |
| init_done | input | 1 | Initialization finished pulse |
| temp_ok | input | 1 | Operating temperature reached pulse |
| go_online | input | 1 | Online command pulse |
| go_offline | input | 1 | Offline command pulse |
| overload | input | 1 | Load overload pulse |
| fault | input | 1 | Error detected pulse |
| stop_req | input | 1 | Shutdown request pulse |
| mode_o | output | 3 | Current mode code |
| load_en | output | 1 | Load connected |
| psu_en | output | 1 | Power supply on |
| valve_open | output | 1 | Gas valves open |
| fan_force | output | 1 | Fan forced on |

## Verification
The hardest case to reach is a fault or stop request that arrives in the same cycle as an event that would otherwise be accepted. Examples are go_offline while Online, init_done during Startup and temp_ok during Warmup. Each of these needs the plant first walked to the right mode before the conflicting pulses are driven together. The bench walks the whole lifecycle several times and enters Shutdown from a different mode each time. It also keeps driving power pulses during the purge, so an early exit from Shutdown shows up on mode_o and the actuator outputs.

// File: rtl/pm_seq_pkg.sv
package pm_seq_pkg;
   typedef enum logic [2:0] {
      PM_OFF   = 3'd0,
      PM_START = 3'd1,
      PM_WARM  = 3'd2,
      PM_IDLE  = 3'd3,
      PM_LIVE  = 3'd4,
      PM_DRAIN = 3'd5
   } pm_mode_e;

   typedef struct packed {
      logic power;
      logic init_done;
      logic temp_ok;
      logic go_online;
      logic go_offline;
      logic overload;
      logic fault;
      logic stop_req;
   } pm_evt_s;

   typedef struct packed {
      logic load_en;
      logic psu_en;
      logic valve_open;
      logic fan_force;
   } pm_drive_s;
endpackage

// File: rtl/pm_next_mode.sv
module pm_next_mode
   import pm_seq_pkg::*;
(
   input  pm_mode_e cur,
   input  pm_evt_s  evt,
   input  logic     drain_done,
   output pm_mode_e nxt
);
   logic abort;
   assign abort = evt.fault | evt.stop_req;

   always_comb begin
      nxt = cur;
      unique case (cur)
         PM_OFF:   if (evt.power) nxt = PM_START;
         PM_START: if (abort) nxt = PM_DRAIN;
                   else if (evt.init_done) nxt = PM_WARM;
         PM_WARM:  if (abort) nxt = PM_DRAIN;
                   else if (evt.temp_ok) nxt = PM_IDLE;
         PM_IDLE:  if (abort) nxt = PM_DRAIN;
                   else if (evt.go_online) nxt = PM_LIVE;
         PM_LIVE:  if (abort) nxt = PM_DRAIN;
                   else if (evt.go_offline | evt.overload) nxt = PM_IDLE;
         PM_DRAIN: if (drain_done) nxt = PM_OFF;
         default:  nxt = PM_OFF;
      endcase
   end
endmodule

// File: rtl/pm_drain_timer.sv
module pm_drain_timer
   import pm_seq_pkg::*;
#(
   parameter int DRAIN_CYCLES = 16
)(
   input  logic     clk,
   input  logic     rst_n,
   input  pm_mode_e cur,
   input  pm_mode_e nxt,
   output logic     done
);
   localparam int CW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD_VAL = CW'(DRAIN_CYCLES - 1);

   logic [CW-1:0] left_q;
   logic          entering;

   assign entering = (nxt == PM_DRAIN) && (cur != PM_DRAIN);

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (entering)
         left_q <= LOAD_VAL;
      else if ((cur == PM_DRAIN) && (left_q != '0))
         left_q <= left_q - 1'b1;
   end

   assign done = (cur == PM_DRAIN) && (left_q == '0);
endmodule

// File: rtl/pm_drive_decode.sv
module pm_drive_decode
   import pm_seq_pkg::*;
(
   input  pm_mode_e  cur,
   output pm_drive_s drv
);
   always_comb begin
      drv = '0;
      unique case (cur)
         PM_OFF:   drv = '0;
         PM_START: drv.psu_en = 1'b1;
         PM_WARM,
         PM_IDLE:  begin drv.psu_en = 1'b1; drv.valve_open = 1'b1; end
         PM_LIVE:  begin drv.psu_en = 1'b1; drv.valve_open = 1'b1; drv.load_en = 1'b1; end
         PM_DRAIN: begin drv.psu_en = 1'b1; drv.fan_force = 1'b1; end
         default:  drv = '0;
      endcase
   end
endmodule

// File: rtl/plant_mode_seq.sv
module plant_mode_seq
   import pm_seq_pkg::*;
#(
   parameter int DRAIN_CYCLES = 16
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       power,
   input  logic       init_done,
   input  logic       temp_ok,
   input  logic       go_online,
   input  logic       go_offline,
   input  logic       overload,
   input  logic       fault,
   input  logic       stop_req,
   output logic [2:0] mode_o,
   output logic       load_en,
   output logic       psu_en,
   output logic       valve_open,
   output logic       fan_force
);
   if (DRAIN_CYCLES < 1) begin : g_bad_drain
      $error("plant_mode_seq: DRAIN_CYCLES must be at least 1");
   end

   pm_mode_e  mode_q, mode_d;
   pm_evt_s   evt;
   pm_drive_s drv;
   logic      drain_done;

   assign evt = '{power: power, init_done: init_done, temp_ok: temp_ok,
                  go_online: go_online, go_offline: go_offline,
                  overload: overload, fault: fault, stop_req: stop_req};

   pm_next_mode u_next (
      .cur        (mode_q),
      .evt        (evt),
      .drain_done (drain_done),
      .nxt        (mode_d)
   );

   pm_drain_timer #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (mode_q),
      .nxt   (mode_d),
      .done  (drain_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= PM_OFF;
      else        mode_q <= mode_d;
   end

   pm_drive_decode u_drive (
      .cur (mode_q),
      .drv (drv)
   );

   assign mode_o     = mode_q;
   assign load_en    = drv.load_en;
   assign psu_en     = drv.psu_en;
   assign valve_open = drv.valve_open;
   assign fan_force  = drv.fan_force;
endmodule

// File: rtl/plant_mode_seq_chk.sv
module plant_mode_seq_chk #(
   parameter int DRAIN_CYCLES = 16
)(
   input logic       clk,
   input logic       rst_n,
   input logic       power,
   input logic       init_done,
   input logic       temp_ok,
   input logic       go_online,
   input logic       go_offline,
   input logic       overload,
   input logic       fault,
   input logic       stop_req,
   input logic [2:0] mode_o,
   input logic       load_en,
   input logic       psu_en,
   input logic       valve_open,
   input logic       fan_force
);
   localparam int SW = $clog2(DRAIN_CYCLES + 2) + 1;
   logic [SW-1:0] sd_len;
   logic          active;

   assign active = (mode_o >= 3'd1) && (mode_o <= 3'd4);

   always_ff @(posedge clk) begin
      if (!rst_n)             sd_len <= '0;
      else if (mode_o == 3'd5) sd_len <= sd_len + 1'b1;
      else                    sd_len <= '0;
   end

   p_off_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0) |-> !(load_en | psu_en | valve_open | fan_force));

   p_off_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd0 && !power) |=> (mode_o == 3'd0));

   p_load_only_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (mode_o == 3'd4));

   p_overload_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !fault && !stop_req && overload) |=> (mode_o == 3'd3));

   p_abort_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (fault || stop_req)) |=> (mode_o == 3'd5));

   p_drain_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5) |-> (fan_force && psu_en && !valve_open && !load_en));

   p_drain_exit_only_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd0));

   p_drain_not_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5 && sd_len < SW'(DRAIN_CYCLES - 1)) |=> (mode_o == 3'd5));

   p_drain_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5 && sd_len == SW'(DRAIN_CYCLES - 1)) |=> (mode_o == 3'd0));

   p_warm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && !temp_ok && !fault && !stop_req) |=> (mode_o == 3'd2));
endmodule

bind plant_mode_seq plant_mode_seq_chk #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_chk (.*);

// File: tb/tb_plant_mode_seq.sv
`timescale 1ns/1ps
module tb_plant_mode_seq;
   localparam int N = 6;
   localparam logic [7:0] E_PWR = 8'h01, E_INIT = 8'h02, E_TEMP = 8'h04, E_ON = 8'h08,
                          E_OFF = 8'h10, E_OVL = 8'h20, E_FLT = 8'h40, E_STOP = 8'h80;

   typedef struct { logic [2:0] mode; logic [3:0] outs; string tag; } exp_t;

   logic clk = 0, rst_n = 0;
   logic [7:0] ev = '0;
   logic [2:0] mode_o;
   logic load_en, psu_en, valve_open, fan_force;
   int checks = 0, fails = 0;
   exp_t q[$];
   int m = 0, sd_left = 0;

   always #2.5 clk = ~clk;

   plant_mode_seq #(.DRAIN_CYCLES(N)) dut (
      .clk(clk), .rst_n(rst_n),
      .power(ev[0]), .init_done(ev[1]), .temp_ok(ev[2]), .go_online(ev[3]),
      .go_offline(ev[4]), .overload(ev[5]), .fault(ev[6]), .stop_req(ev[7]),
      .mode_o(mode_o), .load_en(load_en), .psu_en(psu_en),
      .valve_open(valve_open), .fan_force(fan_force));

   // outputs packed {load, psu, valve, fan}
   function automatic logic [3:0] outs_of(int md);
      case (md)
         1: return 4'b0100;
         2, 3: return 4'b0110;
         4: return 4'b1110;
         5: return 4'b0101;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic compare(input logic [2:0] em, input logic [3:0] eo, input string tag);
      logic [3:0] ao;
      ao = {load_en, psu_en, valve_open, fan_force};
      checks++;
      if (mode_o !== em || ao !== eo) begin
         fails++;
         $display("FAIL %s: mode=%0d outs=%b expected mode=%0d outs=%b", tag, mode_o, ao, em, eo);
      end
   endtask

   task automatic step(input logic [7:0] e, input string tag);
      exp_t x;
      int nm;
      @(negedge clk);
      ev = e;
      nm = m;
      case (m)
         0: if (e & E_PWR) nm = 1;
         1, 2, 3, 4: begin
            if (e & (E_FLT | E_STOP)) nm = 5;
            else if (m == 1 && (e & E_INIT)) nm = 2;
            else if (m == 2 && (e & E_TEMP)) nm = 3;
            else if (m == 3 && (e & E_ON)) nm = 4;
            else if (m == 4 && (e & (E_OFF | E_OVL))) nm = 3;
         end
         5: begin sd_left--; if (sd_left == 0) nm = 0; end
         default: nm = 0;
      endcase
      if (nm == 5 && m != 5) sd_left = N;
      m = nm;
      x.mode = 3'(m); x.outs = outs_of(m); x.tag = tag;
      q.push_back(x);
   endtask

   task automatic purge(input string tag);
      for (int i = 0; i < N; i++) step((i % 2) ? E_PWR : (E_INIT | E_FLT), tag);
   endtask

   initial begin : monitor
      exp_t x;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            x = q.pop_front();
            compare(x.mode, x.outs, x.tag);
         end
      end
   end

   initial begin : watchdog
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      compare(3'd0, 4'b0000, "R1");
      rst_n = 1;
      @(posedge clk); #1;
      compare(3'd0, 4'b0000, "R1");
      // Off ignores everything but power
      step(E_FLT | E_STOP | E_INIT | E_ON, "R2");
      step(E_TEMP | E_OVL | E_OFF, "R9");
      step(E_PWR, "R2");
      step(8'h00, "R3");
      step(E_TEMP | E_ON | E_OFF, "R9");
      step(E_INIT, "R3");
      step(E_ON | E_PWR, "R9");
      step(E_TEMP, "R4");
      step(E_OVL | E_INIT, "R9");
      step(E_ON, "R5");
      step(8'h00, "R6");
      step(E_OFF, "R6");
      step(E_ON, "R5");
      step(E_OVL, "R6");
      step(E_ON, "R5");
      step(E_OFF | E_FLT, "R7");
      purge("R8");
      step(8'h00, "R2");
      // abort in Startup against init_done
      step(E_PWR, "R2");
      step(E_STOP | E_INIT, "R7");
      purge("R8");
      // abort in Warmup against temp_ok
      step(E_PWR, "R2");
      step(E_INIT, "R3");
      step(E_FLT | E_TEMP, "R7");
      purge("R8");
      // abort in Offline against go_online
      step(E_PWR, "R2");
      step(E_INIT, "R3");
      step(E_TEMP, "R4");
      step(E_STOP | E_ON, "R7");
      purge("R8");
      // abort while Online against overload
      step(E_PWR, "R2");
      step(E_INIT, "R3");
      step(E_TEMP, "R4");
      step(E_ON, "R5");
      step(E_STOP | E_OVL, "R7");
      purge("R8");
      step(8'h00, "R1");
      @(negedge clk); ev = '0;
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule